// File: doc/BRIEF.md
# Mode-Controlled MESI Cache Policy Unit

This block makes the per-access decision for a small write-back data cache. Two global control bits set the behaviour: `cache_disable` and `no_write_thru`. For each processor read or write, the unit looks up the addressed line in its register-based tag/state store and reports four things. It says whether the cache serves the access, whether a line may be allocated, whether memory must be accessed, and which MESI state the line takes next. The state store is updated on the same clock edge.

There are two operating modes. In write-back mode, misses allocate and lines follow ordinary MESI transitions. In frozen mode, the cache contents stay fixed. Hits are still served and may upgrade Exclusive to Modified. Misses never allocate. Shared lines stay Shared on a write, and snoops never invalidate a line. The unit also accepts external snoops, which can be gated off in uniprocessor operation while caching is disabled. Accepted snoops are checked for even address parity. Two explicit commands are provided: a one-cycle invalidate and a walking write-back-invalidate that hands each Modified line to memory through a request/done handshake.

Top module: `cache_mode_policy`

## Requirements
- R1: After reset every line is Invalid, so every lookup misses. `flush_busy`, `flush_done`, `flush_wb_req`, `snp_hit`, `snp_wb_req` and `snp_parity_err` are all low.
- R2: The mode depends only on `cache_disable`. When it is 0 the unit is in write-back mode, and when it is 1 the unit is in frozen mode; `no_write_thru` changes nothing. `next_state` encodes Invalid=0, Shared=1, Exclusive=2, Modified=3. A lookup hits (`acc_hit`) when the stored tag equals `acc_tag` and the state is not Invalid.
- R3: In write-back mode, a read hit sets `use_cache` with no memory access and keeps the state. A read miss sets `allocate` and `mem_access`, and the line becomes Exclusive, or Shared when `shared_hint` is high. A miss replaces whatever line held that index.
- R4: In write-back mode, a write hit sets `use_cache` and the line becomes Modified. `mem_access` is set only when the line was Shared. A write miss sets `allocate` and `mem_access`, and the line becomes Modified.
- R5: In frozen mode, a read hit is served from the cache with the state kept. A read miss sets only `mem_access`, and the stored line (tag and state) is left untouched.
- R6: In frozen mode, a write hit sets `use_cache`. Exclusive or Modified becomes Modified with no memory access. Shared stays Shared and also sets `mem_access`.
- R7: In frozen mode, a write miss sets only `mem_access` and allocates nothing.
- R8: A snoop is accepted when `cache_disable` is 0 or `dual_proc` is 1. An ignored snoop produces no `snp_hit`, no `snp_wb_req` and no `snp_parity_err`, and leaves line state unchanged.
- R9: For an accepted snoop, `snp_parity_err` pulses for one cycle, one cycle after `snp_valid`, when the XOR of `snp_addr` and `snp_parity` is 1 (odd parity). This applies whether the snoop hits or misses.
- R10: The snoop address is {tag, index}. In write-back mode, a snoop hit pulses `snp_hit` one cycle later, also pulses `snp_wb_req` if the line was Modified, and makes the line Invalid. A snoop miss changes no state.
- R11: In frozen mode, an accepted snoop hit still pulses `snp_hit` and, for a Modified line, `snp_wb_req`, but the line keeps its state.
- R12: `cmd_inv` makes every line Invalid one cycle later in either mode, with no write-back.
- R13: `cmd_wbinv` walks indices in ascending order with `flush_busy` high. For each Modified line it holds `flush_wb_req` with `flush_wb_index` until `flush_wb_done`. It then pulses `flush_done` for one cycle, after which every line is Invalid. This works in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cache_disable | input | 1 | Cache-disable control bit |
| no_write_thru | input | 1 | Not-write-through control bit |
| dual_proc | input | 1 | 1 = dual-processor system, 0 = uniprocessor |
| acc_valid | input | 1 | Processor access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_index | input | IDX_W | Line index of the access |
| acc_tag | input | TAG_W | Tag of the access |
| shared_hint | input | 1 | Fill as Shared on a write-back read miss |
| acc_hit | output | 1 | Lookup hit |
| use_cache | output | 1 | Access is served by the cache |
| allocate | output | 1 | Line fill/replacement allowed |
| mem_access | output | 1 | Access goes to memory |
| next_state | output | 2 | Next MESI state of the addressed line |
| snp_valid | input | 1 | Snoop request |
| snp_addr | input | ADDR_W | Snoop address {tag, index} |
| snp_parity | input | 1 | Even parity bit of the snoop address |
| snp_hit | output | 1 | Accepted snoop hit (registered pulse) |
| snp_wb_req | output | 1 | Snoop hit a Modified line (registered pulse) |
| snp_parity_err | output | 1 | Parity error on an accepted snoop (registered pulse) |
| cmd_inv | input | 1 | Invalidate all lines |
| cmd_wbinv | input | 1 | Write back Modified lines, then invalidate all |
| flush_wb_req | output | 1 | Walker requests write-back of a line |
| flush_wb_index | output | IDX_W | Index of the line being written back |
| flush_wb_done | input | 1 | Write-back of the requested line finished |
| flush_busy | output | 1 | Write-back-invalidate walk in progress |
| flush_done | output | 1 | Walk finished (one-cycle pulse) |

## Verification
Every combination of the two control bits is tried against a missing line and a hitting line in each of Shared, Exclusive and Modified, for both reads and writes. This separates the two modes and shows that `no_write_thru` has no effect. Further accesses cover a miss onto an index that holds a valid line of another tag, and a read fill with the shared hint. The replacement case tells allocation apart from a frozen line that must stay put. Snoops are issued with good and bad parity in uniprocessor and dual-processor operation, as hits and misses, in both modes. These cases separate acceptance gating, invalidation and write-back reporting. The walking flush runs with a mix of Modified and clean lines, and again with none, to confirm the order of requests and the final invalidation.

// File: rtl/cpu_policy_pkg.sv
package cpu_policy_pkg;

    typedef enum logic [1:0] {
        LINE_I = 2'd0,
        LINE_S = 2'd1,
        LINE_E = 2'd2,
        LINE_M = 2'd3
    } line_state_t;

    typedef enum logic {
        MODE_WB     = 1'b0,
        MODE_FROZEN = 1'b1
    } cache_mode_t;

    typedef enum logic [1:0] {
        FW_IDLE   = 2'd0,
        FW_WALK   = 2'd1,
        FW_FINISH = 2'd2
    } walk_state_t;

    typedef struct packed {
        logic        use_cache;
        logic        allocate;
        logic        mem_access;
        line_state_t next_state;
    } access_verdict_t;

    // Only the disable bit picks the mode; the other bit is a don't-care.
    function automatic cache_mode_t mode_of(input logic cd, input logic nw);
        case ({cd, nw})
            2'b00, 2'b01: mode_of = MODE_WB;
            default:      mode_of = MODE_FROZEN;
        endcase
    endfunction

    function automatic access_verdict_t decide(
        input cache_mode_t mode,
        input logic        write,
        input logic        hit,
        input line_state_t cur,
        input logic        hint
    );
        access_verdict_t v;
        v = '{use_cache: 1'b0, allocate: 1'b0, mem_access: 1'b0, next_state: cur};
        if (hit) begin
            v.use_cache = 1'b1;
            if (write) begin
                v.mem_access = (cur == LINE_S);
                v.next_state = (mode == MODE_FROZEN && cur == LINE_S) ? LINE_S : LINE_M;
            end
        end else begin
            v.mem_access = 1'b1;
            if (mode == MODE_WB) begin
                v.allocate   = 1'b1;
                v.next_state = write ? LINE_M : (hint ? LINE_S : LINE_E);
            end
        end
        return v;
    endfunction

endpackage

// File: rtl/cpu_line_store.sv
module cpu_line_store
    import cpu_policy_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int TAG_W     = 8,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_all,
    input  logic              acc_we,
    input  logic [IDX_W-1:0]  acc_idx,
    input  logic [TAG_W-1:0]  acc_tag,
    input  line_state_t       acc_state,
    input  logic              snp_we,
    input  logic [IDX_W-1:0]  snp_idx,
    output logic [TAG_W-1:0]  tag_a,
    output line_state_t       st_a,
    output logic [TAG_W-1:0]  tag_s,
    output line_state_t       st_s,
    input  logic [IDX_W-1:0]  rd_f_idx,
    output line_state_t       st_f
);
    logic [TAG_W-1:0] tag_q [NUM_LINES];
    line_state_t      st_q  [NUM_LINES];

    generate
        for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
            always_ff @(posedge clk) begin
                if (rst) begin
                    tag_q[g] <= '0;
                    st_q[g]  <= LINE_I;
                end else if (clear_all) begin
                    st_q[g]  <= LINE_I;
                end else if (snp_we && snp_idx == IDX_W'(g)) begin
                    st_q[g]  <= LINE_I;
                end else if (acc_we && acc_idx == IDX_W'(g)) begin
                    tag_q[g] <= acc_tag;
                    st_q[g]  <= acc_state;
                end
            end

            // R12
            clear_line_chk: assert property (@(posedge clk) disable iff (rst)
                clear_all |=> st_q[g] == LINE_I);
        end
    endgenerate

    assign tag_a = tag_q[acc_idx];
    assign st_a  = st_q[acc_idx];
    assign tag_s = tag_q[snp_idx];
    assign st_s  = st_q[snp_idx];
    assign st_f  = st_q[rd_f_idx];

endmodule

// File: rtl/cpu_snoop_unit.sv
module cpu_snoop_unit
    import cpu_policy_pkg::*;
#(
    parameter int TAG_W   = 8,
    parameter int IDX_W   = 3,
    localparam int ADDR_W = TAG_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  cache_mode_t       mode,
    input  logic              cache_disable,
    input  logic              dual_proc,
    input  logic              snp_valid,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic              snp_parity,
    input  logic [TAG_W-1:0]  line_tag,
    input  line_state_t       line_state,
    output logic [IDX_W-1:0]  line_idx,
    output logic              inval_we,
    output logic              hit_q,
    output logic              wb_q,
    output logic              perr_q
);
    logic accepted, hit;

    assign line_idx = snp_addr[IDX_W-1:0];
    assign accepted = snp_valid && (!cache_disable || dual_proc);
    assign hit      = accepted && (line_state != LINE_I)
                      && (line_tag == snp_addr[ADDR_W-1:IDX_W]);
    assign inval_we = hit && (mode == MODE_WB);

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_q  <= 1'b0;
            wb_q   <= 1'b0;
            perr_q <= 1'b0;
        end else begin
            hit_q  <= hit;
            wb_q   <= hit && (line_state == LINE_M);
            perr_q <= accepted && (^{snp_addr, snp_parity});
        end
    end

    // R8
    perr_only_accepted_chk: assert property (@(posedge clk) disable iff (rst)
        perr_q |-> $past(snp_valid && (!cache_disable || dual_proc)));

    // R10
    wb_implies_hit_chk: assert property (@(posedge clk) disable iff (rst)
        wb_q |-> hit_q);

endmodule

// File: rtl/cpu_flush_walker.sv
module cpu_flush_walker
    import cpu_policy_pkg::*;
#(
    parameter int NUM_LINES = 8,
    localparam int IDX_W    = $clog2(NUM_LINES),
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_LINES - 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  line_state_t      line_state,
    output logic [IDX_W-1:0] ptr,
    output logic             wb_req,
    input  logic             wb_done,
    output logic             busy,
    output logic             done
);
    walk_state_t state_q;
    logic        advance;

    assign wb_req  = (state_q == FW_WALK) && (line_state == LINE_M);
    assign advance = !wb_req || wb_done;
    assign busy    = (state_q != FW_IDLE);
    assign done    = (state_q == FW_FINISH);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FW_IDLE;
            ptr     <= '0;
        end else begin
            case (state_q)
                FW_IDLE: if (start) begin
                    state_q <= FW_WALK;
                    ptr     <= '0;
                end
                FW_WALK: if (advance) begin
                    if (ptr == LAST_IDX) state_q <= FW_FINISH;
                    else                 ptr     <= ptr + 1'b1;
                end
                default: state_q <= FW_IDLE;
            endcase
        end
    end

    // R13
    wb_req_in_walk_chk: assert property (@(posedge clk) disable iff (rst)
        wb_req |-> busy);

    // R13
    done_ends_walk_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    // R13
    req_held_chk: assert property (@(posedge clk) disable iff (rst)
        (wb_req && !wb_done) |=> wb_req && $stable(ptr));

endmodule

// File: rtl/cache_mode_policy.sv
module cache_mode_policy
    import cpu_policy_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int TAG_W     = 8,
    localparam int IDX_W    = $clog2(NUM_LINES),
    localparam int ADDR_W   = TAG_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cache_disable,
    input  logic              no_write_thru,
    input  logic              dual_proc,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [IDX_W-1:0]  acc_index,
    input  logic [TAG_W-1:0]  acc_tag,
    input  logic              shared_hint,
    output logic              acc_hit,
    output logic              use_cache,
    output logic              allocate,
    output logic              mem_access,
    output logic [1:0]        next_state,
    input  logic              snp_valid,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic              snp_parity,
    output logic              snp_hit,
    output logic              snp_wb_req,
    output logic              snp_parity_err,
    input  logic              cmd_inv,
    input  logic              cmd_wbinv,
    output logic              flush_wb_req,
    output logic [IDX_W-1:0]  flush_wb_index,
    input  logic              flush_wb_done,
    output logic              flush_busy,
    output logic              flush_done
);
    cache_mode_t      mode;
    access_verdict_t  verdict;
    logic [TAG_W-1:0] tag_a, tag_s;
    line_state_t      st_a, st_s, st_f;
    logic [IDX_W-1:0] snp_idx;
    logic             snp_inval, hit_a, clear_all, acc_we, walk_start;

    assign mode    = mode_of(cache_disable, no_write_thru);
    assign hit_a   = (tag_a == acc_tag) && (st_a != LINE_I);

    always_comb begin
        verdict = decide(mode, acc_write, hit_a, st_a, shared_hint);
    end

    assign acc_hit    = acc_valid && hit_a;
    assign use_cache  = acc_valid && verdict.use_cache;
    assign allocate   = acc_valid && verdict.allocate;
    assign mem_access = acc_valid && verdict.mem_access;
    assign next_state = acc_valid ? verdict.next_state : st_a;

    assign acc_we     = acc_valid && !flush_busy && (verdict.allocate || hit_a);
    assign clear_all  = (cmd_inv && !flush_busy) || flush_done;
    assign walk_start = cmd_wbinv && !cmd_inv && !flush_busy;

    cpu_line_store #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .clear_all (clear_all),
        .acc_we    (acc_we),
        .acc_idx   (acc_index),
        .acc_tag   (acc_tag),
        .acc_state (verdict.next_state),
        .snp_we    (snp_inval),
        .snp_idx   (snp_idx),
        .tag_a     (tag_a),
        .st_a      (st_a),
        .tag_s     (tag_s),
        .st_s      (st_s),
        .rd_f_idx  (flush_wb_index),
        .st_f      (st_f)
    );

    cpu_snoop_unit #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_snoop (
        .clk           (clk),
        .rst           (rst),
        .mode          (mode),
        .cache_disable (cache_disable),
        .dual_proc     (dual_proc),
        .snp_valid     (snp_valid),
        .snp_addr      (snp_addr),
        .snp_parity    (snp_parity),
        .line_tag      (tag_s),
        .line_state    (st_s),
        .line_idx      (snp_idx),
        .inval_we      (snp_inval),
        .hit_q         (snp_hit),
        .wb_q          (snp_wb_req),
        .perr_q        (snp_parity_err)
    );

    cpu_flush_walker #(.NUM_LINES(NUM_LINES)) u_walker (
        .clk        (clk),
        .rst        (rst),
        .start      (walk_start),
        .line_state (st_f),
        .ptr        (flush_wb_index),
        .wb_req     (flush_wb_req),
        .wb_done    (flush_wb_done),
        .busy       (flush_busy),
        .done       (flush_done)
    );

    // R5 R7
    frozen_no_alloc_chk: assert property (@(posedge clk) disable iff (rst)
        (cache_disable && acc_valid) |-> !allocate);

    // R6
    frozen_shared_stays_chk: assert property (@(posedge clk) disable iff (rst)
        (cache_disable && acc_valid && acc_write && acc_hit && st_a == LINE_S)
            |-> (next_state == 2'd1 && mem_access));

    // R4
    wb_write_to_modified_chk: assert property (@(posedge clk) disable iff (rst)
        (!cache_disable && acc_valid && acc_write) |-> next_state == 2'd3);

endmodule

// File: tb/cache_mode_policy_test.sv
module cache_mode_policy_test;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 8;
    localparam int TW = 8;
    localparam int IW = 3;
    localparam int AW = TW + IW;

    logic clk = 1'b0, rst = 1'b1;
    logic cache_disable = 0, no_write_thru = 0, dual_proc = 0;
    logic acc_valid = 0, acc_write = 0, shared_hint = 0;
    logic [IW-1:0] acc_index = '0;
    logic [TW-1:0] acc_tag = '0;
    logic acc_hit, use_cache, allocate, mem_access;
    logic [1:0] next_state;
    logic snp_valid = 0, snp_parity = 0;
    logic [AW-1:0] snp_addr = '0;
    logic snp_hit, snp_wb_req, snp_parity_err;
    logic cmd_inv = 0, cmd_wbinv = 0, flush_wb_done = 0;
    logic flush_wb_req, flush_busy, flush_done;
    logic [IW-1:0] flush_wb_index;

    always #(CLK_PERIOD/2) clk = ~clk;

    cache_mode_policy #(.NUM_LINES(NL), .TAG_W(TW)) uut (
        .clk(clk), .rst(rst), .cache_disable(cache_disable), .no_write_thru(no_write_thru),
        .dual_proc(dual_proc), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_index(acc_index), .acc_tag(acc_tag), .shared_hint(shared_hint),
        .acc_hit(acc_hit), .use_cache(use_cache), .allocate(allocate),
        .mem_access(mem_access), .next_state(next_state), .snp_valid(snp_valid),
        .snp_addr(snp_addr), .snp_parity(snp_parity), .snp_hit(snp_hit),
        .snp_wb_req(snp_wb_req), .snp_parity_err(snp_parity_err), .cmd_inv(cmd_inv),
        .cmd_wbinv(cmd_wbinv), .flush_wb_req(flush_wb_req), .flush_wb_index(flush_wb_index),
        .flush_wb_done(flush_wb_done), .flush_busy(flush_busy), .flush_done(flush_done)
    );

    typedef struct {
        logic       hit;
        logic       use_c;
        logic       alloc;
        logic       mem;
        logic [1:0] nxt;
        string      req;
    } exp_t;

    exp_t  sbq[$];
    int    checks = 0;
    int    fails  = 0;
    int    mstate[NL];
    int    mtag[NL];
    event  mon_ev;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Expected outcome from the requirements: states I=0 S=1 E=2 M=3.
    function automatic exp_t predict(bit frozen, bit w, int cur, bit hit, bit hint, string req);
        exp_t e;
        e.req = req;
        e.hit = hit;
        if (hit) begin
            e.use_c = 1; e.alloc = 0;
            if (!w)            begin e.mem = 0; e.nxt = 2'(cur); end
            else if (cur == 1) begin e.mem = 1; e.nxt = frozen ? 2'd1 : 2'd3; end
            else               begin e.mem = 0; e.nxt = 2'd3; end
        end else begin
            e.use_c = 0; e.mem = 1; e.alloc = !frozen;
            if (frozen) e.nxt = 2'(cur);
            else        e.nxt = w ? 2'd3 : (hint ? 2'd1 : 2'd2);
        end
        return e;
    endfunction

    initial forever begin
        exp_t e;
        @(mon_ev);
        e = sbq.pop_front();
        chk(acc_hit == e.hit, e.req, "acc_hit", int'(acc_hit), int'(e.hit));
        chk(use_cache == e.use_c, e.req, "use_cache", int'(use_cache), int'(e.use_c));
        chk(allocate == e.alloc, e.req, "allocate", int'(allocate), int'(e.alloc));
        chk(mem_access == e.mem, e.req, "mem_access", int'(mem_access), int'(e.mem));
        chk(next_state == e.nxt, e.req, "next_state", int'(next_state), int'(e.nxt));
    end

    task automatic access(input bit w, input int idx, input int tag, input bit hint,
                          input string req);
        exp_t e;
        int   cur;
        bit   hit;
        @(negedge clk);
        acc_valid = 1; acc_write = w; acc_index = IW'(idx);
        acc_tag = TW'(tag); shared_hint = hint;
        cur = mstate[idx];
        hit = (cur != 0) && (mtag[idx] == tag);
        e = predict(cache_disable, w, cur, hit, hint, req);
        sbq.push_back(e);
        #2 -> mon_ev;
        @(posedge clk);
        #1 acc_valid = 0;
        if (e.alloc || hit) begin
            mtag[idx] = tag;
            mstate[idx] = int'(e.nxt);
        end
    endtask

    task automatic set_mode(input bit cd, input bit nw);
        @(negedge clk);
        cache_disable = cd; no_write_thru = nw;
    endtask

    task automatic inv_all();
        @(negedge clk); cmd_inv = 1;
        @(negedge clk); cmd_inv = 0;
        foreach (mstate[i]) mstate[i] = 0;
    endtask

    // Bring a line to state st (1=S, 2=E, 3=M) in write-back mode.
    task automatic prep(input int idx, input int tag, input int st);
        if (st == 1)      access(0, idx, tag, 1, "R3");
        else if (st == 2) access(0, idx, tag, 0, "R3");
        else if (st == 3) access(1, idx, tag, 0, "R4");
    endtask

    task automatic snoop(input int idx, input int tag, input bit bad);
        logic [AW-1:0] a;
        a = {TW'(tag), IW'(idx)};
        @(negedge clk);
        snp_valid = 1; snp_addr = a; snp_parity = (^a) ^ bad;
        @(negedge clk);
        snp_valid = 0;
    endtask

    task automatic run_wbinv(input int exp_list[$], input string req);
        int got[$];
        @(negedge clk); cmd_wbinv = 1;
        @(negedge clk); cmd_wbinv = 0;
        chk(flush_busy == 1, req, "flush_busy during walk", int'(flush_busy), 1);
        for (int n = 0; n < 200 && !flush_done; n++) begin
            if (flush_wb_req) begin
                got.push_back(int'(flush_wb_index));
                flush_wb_done = 1;
            end else begin
                flush_wb_done = 0;
            end
            @(negedge clk);
        end
        flush_wb_done = 0;
        chk(flush_done == 1, req, "flush_done pulse", int'(flush_done), 1);
        chk(got.size() == exp_list.size(), req, "write-back count", got.size(), exp_list.size());
        for (int k = 0; k < got.size() && k < exp_list.size(); k++)
            chk(got[k] == exp_list[k], req, "write-back index", got[k], exp_list[k]);
        @(negedge clk);
        chk(flush_busy == 0 && flush_done == 0, req, "walk ended", int'(flush_busy), 0);
        foreach (mstate[i]) mstate[i] = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        foreach (mstate[i]) begin mstate[i] = 0; mtag[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(flush_busy == 0, "R1", "flush_busy", int'(flush_busy), 0);
        chk(flush_done == 0 && flush_wb_req == 0, "R1", "flush outputs", int'(flush_done), 0);
        chk(snp_hit == 0 && snp_wb_req == 0 && snp_parity_err == 0, "R1", "snoop pulses",
            int'(snp_hit), 0);
        for (int i = 0; i < NL; i++) access(0, i, 0, 0, "R1");
        inv_all();

        // R2..R7: every mode pair x line state x direction
        for (int m = 0; m < 4; m++)
            for (int cs = 0; cs < 4; cs++)
                for (int w = 0; w < 2; w++) begin
                    string r;
                    if (m < 2) r = w ? "R2 R4" : "R2 R3";
                    else if (w == 0) r = "R2 R5";
                    else r = (cs == 0) ? "R2 R7" : "R2 R6";
                    set_mode(0, 0);
                    inv_all();
                    if (cs != 0) prep(6, 8'h5A, cs);
                    set_mode(m[1], m[0]);
                    access(w[0], 6, 8'h5A, 0, r);
                end

        // R3 shared fill and replacement in write-back mode
        set_mode(0, 0);
        inv_all();
        access(0, 2, 8'h33, 1, "R3");
        access(0, 2, 8'h33, 0, "R3");
        prep(4, 8'h11, 3);
        access(0, 4, 8'h22, 0, "R3");
        access(0, 4, 8'h22, 0, "R3");

        // R5 R7 frozen misses leave the resident line alone
        prep(5, 8'h11, 3);
        set_mode(1, 1);
        access(0, 5, 8'h22, 0, "R5");
        access(1, 5, 8'h22, 0, "R7");
        access(0, 5, 8'h11, 0, "R5");

        // R10 write-back snoop hit on Modified
        set_mode(0, 0);
        dual_proc = 0;
        prep(1, 8'h40, 3);
        snoop(1, 8'h40, 0);
        chk(snp_hit == 1, "R10", "snp_hit", int'(snp_hit), 1);
        chk(snp_wb_req == 1, "R10", "snp_wb_req", int'(snp_wb_req), 1);
        chk(snp_parity_err == 0, "R9", "parity ok", int'(snp_parity_err), 0);
        mstate[1] = 0;
        access(0, 1, 8'h40, 0, "R10");

        // R10 snoop miss changes nothing; R9 bad parity on a miss
        prep(2, 8'h41, 2);
        snoop(2, 8'h42, 1);
        chk(snp_hit == 0 && snp_wb_req == 0, "R10", "snoop miss", int'(snp_hit), 0);
        chk(snp_parity_err == 1, "R9", "parity err", int'(snp_parity_err), 1);
        @(negedge clk);
        chk(snp_parity_err == 0, "R9", "parity pulse width", int'(snp_parity_err), 0);
        access(0, 2, 8'h41, 0, "R10");

        // R8 frozen, uniprocessor: snoop ignored
        prep(3, 8'h50, 3);
        set_mode(1, 1);
        snoop(3, 8'h50, 1);
        chk(snp_hit == 0 && snp_wb_req == 0, "R8", "ignored snoop", int'(snp_hit), 0);
        chk(snp_parity_err == 0, "R8", "no parity check", int'(snp_parity_err), 0);
        access(0, 3, 8'h50, 0, "R8");

        // R11 frozen, dual-processor: reported but not invalidated
        dual_proc = 1;
        snoop(3, 8'h50, 1);
        chk(snp_hit == 1 && snp_wb_req == 1, "R11", "frozen snoop hit", int'(snp_wb_req), 1);
        chk(snp_parity_err == 1, "R9", "dual parity err", int'(snp_parity_err), 1);
        access(0, 3, 8'h50, 0, "R11");
        dual_proc = 0;

        // R12 plain invalidate works in frozen mode
        inv_all();
        access(0, 3, 8'h50, 0, "R12");

        // R13 walk in frozen mode
        set_mode(0, 0);
        prep(1, 8'h61, 3);
        prep(2, 8'h62, 2);
        prep(3, 8'h63, 3);
        prep(5, 8'h65, 1);
        set_mode(1, 0);
        run_wbinv('{1, 3}, "R13");
        access(0, 1, 8'h61, 0, "R13");
        access(0, 2, 8'h62, 0, "R13");
        access(0, 3, 8'h63, 0, "R13");

        // R13 walk with no Modified lines
        set_mode(0, 0);
        prep(7, 8'h77, 2);
        run_wbinv('{}, "R13");
        access(0, 7, 8'h77, 0, "R13");

        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule